// File: doc/BRIEF.md
# Masked Wrapping Burst Address Counter

This block generates addresses for one port of a synchronous memory. On every rising clock edge it takes a 3-bit operation code and an address bus. It then holds, loads, clears or advances its counter, or it works on a mask register. The mask selects which low-order counter bits take part in counting. Bits outside the mask keep the value they were given by the last load or clear.

Each load also copies the start address into a shadow (mirror) register. When an increment finds the masked field already at its maximum, the counter takes the mirror value again instead of rolling over to zero. A burst can therefore be replayed without reloading the start address. When the mask's bit 0 is zero, the counter steps by two, so one port visits only even or only odd addresses.

An active-low interrupt shows that the last increment left the counting field all ones. A flag reports a mask value that does not have the permitted shape. A readback operation returns the mask one clock later and turns off the port's data-bus drive for that cycle.

Top module: `burst_addr_counter`

## Requirements
- R1: Operations are sampled on the rising clock edge. The `op_i` encodings are: 0 hold, 1 increment, 2 load, 3 counter clear, 4 mask set-all, 5 mask load, 6 mask readback, 7 hold. A synchronous `rst` sets the counter and the mirror to 0, the mask to all ones, `int_n_o` to 1, `dq_oe_o` to 0 and `rdbk_o` to 0.
- R2: A load puts `addr_i` on `addr_o` from the next cycle and stores the same value in the mirror.
- R3: With mask bit 0 at one, an increment adds one to the field `addr_o & mask`. Bits where the mask is zero do not change.
- R4: With mask bit 0 at zero, an increment adds two to the field, and bit 0 of the counter keeps its value.
- R5: An increment that starts with the field equal to the mask reloads the counter from the mirror. This repeats on every later wrap.
- R6: After an increment, `int_n_o` is 0 if the new field equals the mask and 1 otherwise.
- R7: A counter clear, load, mask set-all or mask load drives `int_n_o` to 1. A counter clear also sets the counter and the mirror to 0.
- R8: A mask set-all makes every mask bit one. A mask load stores `addr_i` in the mask even when the value is illegal.
- R9: `mask_bad_o` is 1 exactly when the stored mask is not of the form 2^n-1 (n≥1) or 2^n-2 (n≥2). For example 0x1FFFF, 0x003FE and 0x00001 are legal, and 0x1F0FF, 0x003FC and 0x00000 are not.
- R10: A readback puts the mask value on `rdbk_o` in the next cycle. In that same cycle `dq_oe_o` is 0. At other times `dq_oe_o` follows `port_en_i` with a delay of one cycle.
- R11: A hold or a readback leaves `addr_o` and `int_n_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous master reset, active high |
| op_i | input | 3 | Operation code |
| addr_i | input | ADDR_W | Load value for the counter or the mask |
| port_en_i | input | 1 | Port enabled for data transfers |
| addr_o | output | ADDR_W | Current counter value |
| rdbk_o | output | ADDR_W | Mask value captured by the last readback |
| dq_oe_o | output | 1 | Data-bus output enable |
| int_n_o | output | 1 | Active-low interrupt: the counting field is all ones |
| mask_bad_o | output | 1 | Stored mask has an illegal shape |

## Verification
The hardest situation to reach is a second wrap from the mirror under a narrow mask while the step is two. It needs a chosen mask, a start address whose bit 0 is odd, and an exact number of increments, so that the field reaches its maximum and the interrupt falls just before the wrap. The directed tasks load such masks, count the increments in advance and check the address and the interrupt on both sides of each wrap. They also clear the counter before a wrap to show that the mirror was emptied.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_INC   = 3'd1,
    OP_LOAD  = 3'd2,
    OP_CLR   = 3'd3,
    OP_MSET  = 3'd4,
    OP_MLOAD = 3'd5,
    OP_MREAD = 3'd6,
    OP_IDLE7 = 3'd7
  } op_e;
endpackage

// File: rtl/bac_mask_reg.sv
module bac_mask_reg
  import bac_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  op_e          op,
  input  logic [W-1:0] addr_i,
  input  logic         port_en_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] rdbk_o,
  output logic         dq_oe_o,
  output logic         mask_bad_o
);
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] mask_q, rdbk_q;
  logic         oe_q;

  // legal shapes: 0..01..1 or 0..01..10
  function automatic logic shape_ok(input logic [W-1:0] v);
    logic [W-1:0] u;
    u = v | ONE;
    return (v != '0) && ((u & (u + ONE)) == '0);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= ONES;
      rdbk_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= port_en_i && (op != OP_MREAD);
      case (op)
        OP_MSET:  mask_q <= ONES;
        OP_MLOAD: mask_q <= addr_i;
        OP_MREAD: rdbk_q <= mask_q;
        default:  ;
      endcase
    end
  end

  assign mask_o     = mask_q;
  assign rdbk_o     = rdbk_q;
  assign dq_oe_o    = oe_q;
  assign mask_bad_o = !shape_ok(mask_q);
endmodule

// File: rtl/bac_count_core.sv
module bac_count_core
  import bac_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  op_e          op,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] mask,
  output logic [W-1:0] cnt_o,
  output logic         inc_fire_o,
  output logic         inc_wrap_o,
  output logic         next_full_o
);
  logic [W-1:0] cnt_q, mir_q, nxt;

  function automatic logic [W-1:0] field_step(input logic [W-1:0] c,
                                              input logic [W-1:0] m);
    logic [W-1:0] step;
    step = m[0] ? W'(1) : W'(2);
    return (c & ~m) | (((c & m) + step) & m);
  endfunction

  function automatic logic field_full(input logic [W-1:0] c,
                                      input logic [W-1:0] m);
    return (c & m) == m;
  endfunction

  assign inc_fire_o  = (op == OP_INC);
  assign inc_wrap_o  = inc_fire_o && field_full(cnt_q, mask);
  assign nxt         = inc_wrap_o ? mir_q : field_step(cnt_q, mask);
  assign next_full_o = field_full(nxt, mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mir_q <= '0;
    end else begin
      case (op)
        OP_INC:  cnt_q <= nxt;
        OP_LOAD: begin
          cnt_q <= addr_i;
          mir_q <= addr_i;
        end
        OP_CLR: begin
          cnt_q <= '0;
          mir_q <= '0;
        end
        default: ;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bac_irq.sv
module bac_irq
  import bac_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  op_e  op,
  input  logic inc_fire,
  input  logic next_full,
  output logic int_n_o
);
  logic int_n_q;
  logic release_ev;

  assign release_ev = (op == OP_CLR) || (op == OP_LOAD) ||
                      (op == OP_MSET) || (op == OP_MLOAD);

  always_ff @(posedge clk) begin
    if (rst)             int_n_q <= 1'b1;
    else if (release_ev) int_n_q <= 1'b1;
    else if (inc_fire)   int_n_q <= !next_full;
  end

  assign int_n_o = int_n_q;
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import bac_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              port_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] rdbk_o,
  output logic              dq_oe_o,
  output logic              int_n_o,
  output logic              mask_bad_o
);
  op_e               op;
  logic [ADDR_W-1:0] mask_q;
  logic              inc_fire, inc_wrap, next_full;

  assign op = op_e'(op_i);

  bac_mask_reg #(.W(ADDR_W)) u_mask (
    .clk(clk), .rst(rst), .op(op), .addr_i(addr_i), .port_en_i(port_en_i),
    .mask_o(mask_q), .rdbk_o(rdbk_o), .dq_oe_o(dq_oe_o),
    .mask_bad_o(mask_bad_o)
  );

  bac_count_core #(.W(ADDR_W)) u_cnt (
    .clk(clk), .rst(rst), .op(op), .addr_i(addr_i), .mask(mask_q),
    .cnt_o(addr_o), .inc_fire_o(inc_fire), .inc_wrap_o(inc_wrap),
    .next_full_o(next_full)
  );

  bac_irq u_irq (
    .clk(clk), .rst(rst), .op(op), .inc_fire(inc_fire),
    .next_full(next_full), .int_n_o(int_n_o)
  );
endmodule

// File: rtl/bac_checker.sv
module bac_checker
  import bac_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ADDR_W-1:0] rdbk_o,
  input logic              dq_oe_o,
  input logic              int_n_o,
  input logic [ADDR_W-1:0] mask_q,
  input logic              inc_wrap
);
  p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LOAD) |=> (addr_o == $past(addr_i)));

  p_keep_masked_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_INC && !inc_wrap) |=>
      ((addr_o & ~mask_q) == ($past(addr_o) & ~mask_q)));

  p_int_release_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CLR || op_i == OP_LOAD || op_i == OP_MSET || op_i == OP_MLOAD)
      |=> int_n_o);

  p_mask_set_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_MSET) |=> (mask_q == '1));

  p_readback_r10: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_MREAD) |=> (rdbk_o == $past(mask_q)) && !dq_oe_o);

  p_hold_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_HOLD || op_i == OP_MREAD) |=> ($stable(addr_o) && $stable(int_n_o)));
endmodule

bind burst_addr_counter bac_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .addr_i(addr_i), .addr_o(addr_o),
  .rdbk_o(rdbk_o), .dq_oe_o(dq_oe_o), .int_n_o(int_n_o),
  .mask_q(mask_q), .inc_wrap(inc_wrap)
);

// File: tb/tb_burst_addr_counter.sv
module tb_burst_addr_counter;
  localparam int W = 18;
  localparam logic [2:0] HOLD = 3'd0, INC = 3'd1, LOAD = 3'd2, CLR = 3'd3,
                         MSET = 3'd4, MLOAD = 3'd5, MREAD = 3'd6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op_i = HOLD;
  logic [W-1:0] addr_i = '0;
  logic         port_en_i = 1'b0;
  logic [W-1:0] addr_o, rdbk_o;
  logic         dq_oe_o, int_n_o, mask_bad_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  burst_addr_counter #(.ADDR_W(W)) dut (
    .clk(clk), .rst(rst), .op_i(op_i), .addr_i(addr_i), .port_en_i(port_en_i),
    .addr_o(addr_o), .rdbk_o(rdbk_o), .dq_oe_o(dq_oe_o), .int_n_o(int_n_o),
    .mask_bad_o(mask_bad_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one operation, then wait so the registered result is visible
  task automatic do_op(input logic [2:0] op, input logic [W-1:0] a);
    op_i = op;
    addr_i = a;
    @(negedge clk);
    op_i = HOLD;
  endtask

  task automatic incs(input int n);
    for (int i = 0; i < n; i++) do_op(INC, '0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 addr", 32'(addr_o), 0);
    check("R1 int_n", 32'(int_n_o), 1);
    check("R1 dq_oe", 32'(dq_oe_o), 0);
    check("R1 rdbk", 32'(rdbk_o), 0);
    check("R9 reset mask legal", 32'(mask_bad_o), 0);
    do_op(MREAD, '0);
    check("R1 mask all ones", 32'(rdbk_o), 32'h3FFFF);
  endtask

  task automatic t_plain_inc();
    do_op(LOAD, 18'h00010);
    check("R2 load", 32'(addr_o), 32'h10);
    do_op(INC, '0);
    check("R3 inc by one", 32'(addr_o), 32'h11);
  endtask

  task automatic t_wrap_and_int();
    do_op(MLOAD, 18'h0000F);
    check("R9 0xF legal", 32'(mask_bad_o), 0);
    do_op(LOAD, 18'h12345);
    incs(9);
    check("R3 upper kept", 32'(addr_o), 32'h1234E);
    check("R6 int idle", 32'(int_n_o), 1);
    do_op(INC, '0);
    check("R6 field full", 32'(addr_o), 32'h1234F);
    check("R6 int low", 32'(int_n_o), 0);
    do_op(HOLD, '0);
    check("R11 hold addr", 32'(addr_o), 32'h1234F);
    check("R11 hold int", 32'(int_n_o), 0);
    port_en_i = 1'b1;
    do_op(MREAD, '0);
    check("R10 rdbk", 32'(rdbk_o), 32'hF);
    check("R10 oe off", 32'(dq_oe_o), 0);
    check("R11 rdbk addr", 32'(addr_o), 32'h1234F);
    check("R11 rdbk int", 32'(int_n_o), 0);
    do_op(HOLD, '0);
    check("R10 oe follows", 32'(dq_oe_o), 1);
    port_en_i = 1'b0;
    do_op(HOLD, '0);
    check("R10 oe follows low", 32'(dq_oe_o), 0);
    do_op(INC, '0);
    check("R5 wrap to mirror", 32'(addr_o), 32'h12345);
    check("R6 int released", 32'(int_n_o), 1);
    incs(10);
    check("R5 second pass full", 32'(addr_o), 32'h1234F);
    do_op(INC, '0);
    check("R5 second wrap", 32'(addr_o), 32'h12345);
  endtask

  task automatic t_step2();
    incs(10);
    check("R6 int low again", 32'(int_n_o), 0);
    do_op(MLOAD, 18'h0000E);
    check("R7 mask load releases", 32'(int_n_o), 1);
    check("R9 0xE legal", 32'(mask_bad_o), 0);
    do_op(LOAD, 18'h00A01);
    incs(6);
    check("R4 step two", 32'(addr_o), 32'hA0D);
    check("R6 not full", 32'(int_n_o), 1);
    do_op(INC, '0);
    check("R4 odd max", 32'(addr_o), 32'hA0F);
    check("R6 int low step2", 32'(int_n_o), 0);
    do_op(INC, '0);
    check("R5 step2 wrap", 32'(addr_o), 32'hA01);
  endtask

  task automatic t_clear();
    incs(7);
    check("R6 int low pre-clear", 32'(int_n_o), 0);
    do_op(CLR, '0);
    check("R7 clear addr", 32'(addr_o), 0);
    check("R7 clear int", 32'(int_n_o), 1);
    incs(7);
    check("R4 even max", 32'(addr_o), 32'hE);
    do_op(INC, '0);
    check("R7 mirror cleared", 32'(addr_o), 0);
  endtask

  task automatic t_mask_shapes();
    incs(7);
    check("R6 int low pre-mask", 32'(int_n_o), 0);
    do_op(MLOAD, 18'h1FFFF);
    check("R7 mask load int", 32'(int_n_o), 1);
    check("R9 1FFFF legal", 32'(mask_bad_o), 0);
    do_op(MLOAD, 18'h003FE);
    check("R9 003FE legal", 32'(mask_bad_o), 0);
    do_op(MLOAD, 18'h00001);
    check("R9 00001 legal", 32'(mask_bad_o), 0);
    do_op(MLOAD, 18'h1F0FF);
    check("R9 1F0FF illegal", 32'(mask_bad_o), 1);
    do_op(MREAD, '0);
    check("R8 illegal stored", 32'(rdbk_o), 32'h1F0FF);
    do_op(MLOAD, 18'h003FC);
    check("R9 003FC illegal", 32'(mask_bad_o), 1);
    do_op(MLOAD, 18'h00000);
    check("R9 00000 illegal", 32'(mask_bad_o), 1);
  endtask

  task automatic t_mask_set();
    do_op(MLOAD, 18'h00001);
    do_op(LOAD, 18'h00000);
    do_op(INC, '0);
    check("R6 one-bit field full", 32'(int_n_o), 0);
    do_op(MSET, '0);
    check("R7 mask set releases", 32'(int_n_o), 1);
    do_op(MREAD, '0);
    check("R8 mask set value", 32'(rdbk_o), 32'h3FFFF);
    do_op(INC, '0);
    check("R3 full-width inc", 32'(addr_o), 2);
  endtask

  task automatic t_master_reset();
    do_op(LOAD, 18'h3FFFE);
    do_op(INC, '0);
    check("R6 top full", 32'(int_n_o), 0);
    do_op(MLOAD, 18'h00007);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 rst addr", 32'(addr_o), 0);
    check("R1 rst int", 32'(int_n_o), 1);
    do_op(MREAD, '0);
    check("R1 rst mask", 32'(rdbk_o), 32'h3FFFF);
    do_op(MLOAD, 18'h00001);
    incs(2);
    check("R1 rst mirror zero", 32'(addr_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_plain_inc();
    t_wrap_and_int();
    t_step2();
    t_clear();
    t_mask_shapes();
    t_mask_set();
    t_master_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule